// File: doc/BRIEF.md
# Platform reset control registers

This block is the reset front end of a PC-style platform. It sits on a simple byte-wide I/O bus and answers at two port addresses. The first is a reset-control register. One trigger bit in it fires a reset. Two type bits in the same written byte pick the kind of reset: a CPU-only (soft) reset or a whole-platform (hard) reset. When the trigger bit is clear, the type bits are kept as a persistent setting. The second is a fast gate register. Its bit 1 drives the A20 gate output. Its bit 0 fires a CPU-only reset, but only when that bit rises from 0 to 1.

Each reset leaves the block as a registered pulse one clock long. The pulse appears in the cycle after the write strobe. A hard reset pulse also clears both registers, and any bus write that arrives while that pulse is high is discarded. The reset sequencers that act on the pulses live outside this block.

Top module: `plat_rst_regs`

## Requirements
- R1: While rst_n is low, and after it is released, cpu_rst_pulse, plat_rst_pulse and a20_gate are 0, and both registers read 0x00.
- R2: A write to address 0xCF9 with bit 2 clear keeps only bits 1 and 3 of the data and zeroes the rest. A read of 0xCF9 returns that kept value, and bit 2 always reads 0.
- R3: A write to 0xCF9 with bit 2 set and bit 1 or bit 3 of the same data set produces a platform reset pulse. That write does not change the stored value.
- R4: A write to 0xCF9 with bit 2 set and both bit 1 and bit 3 clear produces a CPU reset pulse and no platform pulse. The stored value is left unchanged.
- R5: A write to address 0x92 stores the whole byte, and a read of 0x92 returns it.
- R6: From the cycle after a write to 0x92, a20_gate equals bit 1 of the written byte.
- R7: A write to 0x92 produces a CPU reset pulse only when data bit 0 is 1 and stored bit 0 was 0. Writing 1 again, or writing 0, produces no pulse.
- R8: Each reset pulse is high for exactly the one cycle after the write strobe edge. The two pulses are never high together.
- R9: In the cycle after a platform pulse, both registers read 0x00 and a20_gate is 0. A CPU pulse leaves both registers unchanged.
- R10: A bus write presented while plat_rst_pulse is high has no effect: no pulse and no register change.
- R11: Reads of any other address return 0xFF. Writes to any other address change nothing and fire nothing. io_rdata is 0x00 when io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one cycle per byte write |
| io_rd | input | 1 | Read enable |
| io_rdata | output | 8 | Read data (combinational) |
| cpu_rst_pulse | output | 1 | CPU-only reset pulse |
| plat_rst_pulse | output | 1 | Whole-platform reset pulse |
| a20_gate | output | 1 | A20 gate level |

## Verification
The hardest case is a write that lands in the one cycle while the platform pulse is high. Only a strictly back-to-back pair of writes reaches it: a hard trigger, then a rising-edge write to the fast gate port on the very next clock. The bench issues exactly that pair. It then checks that no CPU pulse follows and that the gate register still reads zero. The rising-edge rule on port 0x92 needs the same care: the stimulus table writes 1 again, replaces the byte while bit 0 stays high, then writes 0 and 1, so that only true 0-to-1 changes can fire.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef struct packed {
    logic ctl;
    logic gate;
  } prc_sel_t;

  localparam int unsigned PRC_DATA_W = 8;
  localparam logic [PRC_DATA_W-1:0] PRC_UNMAPPED = '1;
endpackage

// File: rtl/prc_rst_sync.sv
module prc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/prc_addr_decode.sv
module prc_addr_decode
  import prc_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]    CTL_ADDR  = 'h0CF9,
  parameter logic [ADDR_W-1:0]    GATE_ADDR = 'h0092
) (
  input  logic [ADDR_W-1:0] addr,
  output prc_sel_t          sel
);
  always_comb begin
    sel.ctl  = (addr == CTL_ADDR);
    sel.gate = (addr == GATE_ADDR);
  end
endmodule

// File: rtl/prc_ctl_reg.sv
module prc_ctl_reg #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TRIG_BIT = 2,
  parameter int unsigned SYS_BIT  = 1,
  parameter int unsigned FULL_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  output logic [DATA_W-1:0] q,
  output logic              hard_req,
  output logic              soft_req
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    (DATA_W'(1) << SYS_BIT) | (DATA_W'(1) << FULL_BIT);

  logic [DATA_W-1:0] q_d;
  logic              q_en;
  logic              trig;

  always_comb begin
    trig     = wr_en && wdata[TRIG_BIT];
    hard_req = trig && ((wdata & KEEP_MASK) != '0);
    soft_req = trig && ((wdata & KEEP_MASK) == '0);
    q_en     = clr || (wr_en && !wdata[TRIG_BIT]);
    q_d      = clr ? '0 : (wdata & KEEP_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  p_keep_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[TRIG_BIT] && !clr) |=> (q == ($past(wdata) & KEEP_MASK)));

  p_trig_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[TRIG_BIT] && !clr) |=> $stable(q));

  p_req_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hard_req && soft_req));
endmodule

// File: rtl/prc_gate_reg.sv
module prc_gate_reg #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned INIT_BIT = 0,
  parameter int unsigned GATE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  output logic [DATA_W-1:0] q,
  output logic              soft_req,
  output logic              a20
);
  logic [DATA_W-1:0] q_d;
  logic              q_en;

  always_comb begin
    q_en     = clr || wr_en;
    q_d      = clr ? '0 : wdata;
    soft_req = wr_en && wdata[INIT_BIT] && !q[INIT_BIT];
    a20      = q[GATE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  p_a20_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (a20 == $past(wdata[GATE_BIT])));

  p_full_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (q == $past(wdata)));

  p_rise_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && q[INIT_BIT]) |-> !soft_req);
endmodule

// File: rtl/prc_pulse_gen.sv
module prc_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_req,
  input  logic soft_req,
  output logic plat_pulse,
  output logic cpu_pulse
);
  logic plat_d;
  logic cpu_d;

  always_comb begin
    plat_d = hard_req;
    cpu_d  = soft_req && !hard_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plat_pulse <= 1'b0;
      cpu_pulse  <= 1'b0;
    end else begin
      plat_pulse <= plat_d;
      cpu_pulse  <= cpu_d;
    end
  end

  p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(plat_pulse && cpu_pulse));
endmodule

// File: rtl/plat_rst_regs.sv
module plat_rst_regs
  import prc_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 'h0CF9,
  parameter logic [ADDR_W-1:0] GATE_ADDR = 'h0092,
  parameter int unsigned       SYNC_STG  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic [PRC_DATA_W-1:0] io_wdata,
  input  logic                  io_wr,
  input  logic                  io_rd,
  output logic [PRC_DATA_W-1:0] io_rdata,
  output logic                  cpu_rst_pulse,
  output logic                  plat_rst_pulse,
  output logic                  a20_gate
);
  localparam int unsigned DW       = PRC_DATA_W;
  localparam int unsigned TRIG_BIT = 2;
  localparam logic [DW-1:0] RD_MASK = ~(DW'(1) << TRIG_BIT);

  logic              rst_ns;
  prc_sel_t          sel;
  logic              wr_ok;
  logic [DW-1:0]     ctl_q;
  logic [DW-1:0]     gate_q;
  logic              ctl_hard, ctl_soft, gate_soft;

  prc_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  prc_addr_decode #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .GATE_ADDR(GATE_ADDR))
    u_dec (.addr(io_addr), .sel(sel));

  always_comb wr_ok = io_wr && !plat_rst_pulse;

  prc_ctl_reg #(.DATA_W(DW), .TRIG_BIT(TRIG_BIT), .SYS_BIT(1), .FULL_BIT(3)) u_ctl (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_ok && sel.ctl), .wdata(io_wdata),
    .clr(plat_rst_pulse), .q(ctl_q), .hard_req(ctl_hard), .soft_req(ctl_soft));

  prc_gate_reg #(.DATA_W(DW), .INIT_BIT(0), .GATE_BIT(1)) u_gate (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_ok && sel.gate), .wdata(io_wdata),
    .clr(plat_rst_pulse), .q(gate_q), .soft_req(gate_soft), .a20(a20_gate));

  prc_pulse_gen u_pulse (
    .clk(clk), .rst_n(rst_ns), .hard_req(ctl_hard),
    .soft_req(ctl_soft || gate_soft),
    .plat_pulse(plat_rst_pulse), .cpu_pulse(cpu_rst_pulse));

  always_comb begin
    if (!io_rd)        io_rdata = '0;
    else if (sel.ctl)  io_rdata = ctl_q & RD_MASK;
    else if (sel.gate) io_rdata = gate_q;
    else               io_rdata = PRC_UNMAPPED;
  end

  p_clear_after_hard_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    plat_rst_pulse |=> (ctl_q == '0 && gate_q == '0 && !a20_gate));

  p_soft_keeps_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (cpu_rst_pulse && !io_wr) |=> ($stable(ctl_q) && $stable(gate_q)));

  p_drop_during_hard_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    plat_rst_pulse |=> (!plat_rst_pulse && !cpu_rst_pulse));

  p_pulse_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (cpu_rst_pulse || plat_rst_pulse) |-> $past(io_wr));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_ns |-> (!cpu_rst_pulse && !plat_rst_pulse && !a20_gate));
endmodule

// File: tb/tb_plat_rst_regs.sv
module tb_plat_rst_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_rdata;
  logic        cpu_rst_pulse, plat_rst_pulse, a20_gate;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  plat_rst_regs dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .cpu_rst_pulse(cpu_rst_pulse), .plat_rst_pulse(plat_rst_pulse),
    .a20_gate(a20_gate));

  // {addr, data, expected 0xCF9 read, expected 0x92 read, 6'b0, cpu, plat}
  localparam int NV = 15;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0CF9, 8'hF3, 8'h02, 8'h00, 6'd0, 1'b0, 1'b0}, // R2
    {16'h0CF9, 8'h08, 8'h08, 8'h00, 6'd0, 1'b0, 1'b0}, // R2
    {16'h0092, 8'h02, 8'h08, 8'h02, 6'd0, 1'b0, 1'b0}, // R5 R6
    {16'h0092, 8'h03, 8'h08, 8'h03, 6'd0, 1'b1, 1'b0}, // R7 rise
    {16'h0092, 8'h03, 8'h08, 8'h03, 6'd0, 1'b0, 1'b0}, // R7 rewrite
    {16'h0092, 8'hA1, 8'h08, 8'hA1, 6'd0, 1'b0, 1'b0}, // R7 stays high
    {16'h0092, 8'h00, 8'h08, 8'h00, 6'd0, 1'b0, 1'b0}, // R7 zero
    {16'h0092, 8'h01, 8'h08, 8'h01, 6'd0, 1'b1, 1'b0}, // R7 rise
    {16'h0CF9, 8'h04, 8'h08, 8'h01, 6'd0, 1'b1, 1'b0}, // R4 R9
    {16'h0070, 8'hFF, 8'h08, 8'h01, 6'd0, 1'b0, 1'b0}, // R11
    {16'h0CF9, 8'h06, 8'h00, 8'h00, 6'd0, 1'b0, 1'b1}, // R3 R9
    {16'h0092, 8'h03, 8'h00, 8'h03, 6'd0, 1'b1, 1'b0}, // R7
    {16'h0CF9, 8'h0C, 8'h00, 8'h00, 6'd0, 1'b0, 1'b1}, // R3 R9
    {16'h0CF9, 8'h0A, 8'h0A, 8'h00, 6'd0, 1'b0, 1'b0}, // R2
    {16'h0CF9, 8'hF4, 8'h0A, 8'h00, 6'd0, 1'b1, 1'b0}  // R4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  // write, then sample pulses one cycle later and again the cycle after
  task automatic wr_chk(input string req, input logic [15:0] a, input logic [7:0] d,
                        input logic ecpu, input logic eplat);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    check({req, " R8 cpu pulse"},  {7'd0, cpu_rst_pulse},  {7'd0, ecpu});
    check({req, " R8 plat pulse"}, {7'd0, plat_rst_pulse}, {7'd0, eplat});
    @(negedge clk);
    check({req, " R8 pulse width"}, {6'd0, cpu_rst_pulse, plat_rst_pulse}, 8'h00);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {5'd0, cpu_rst_pulse, plat_rst_pulse, a20_gate}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(16'h0CF9, r); check("R1 ctl after reset", r, 8'h00);
    rd(16'h0092, r); check("R1 gate after reset", r, 8'h00);
    check("R1 a20 after reset", {7'd0, a20_gate}, 8'h00);
    check("R11 rdata idle", io_rdata, 8'h00);
    rd(16'h0093, r); check("R11 unmapped read", r, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      wr_chk($sformatf("vec%0d", i), VEC[i][47:32], VEC[i][31:24], VEC[i][1], VEC[i][0]);
      rd(16'h0CF9, r); check($sformatf("vec%0d R2 R3 R4 ctl read", i), r, VEC[i][23:16]);
      rd(16'h0092, r); check($sformatf("vec%0d R5 R9 gate read", i), r, VEC[i][15:8]);
      check($sformatf("vec%0d R6 a20", i), {7'd0, a20_gate}, {7'd0, VEC[i][9]});
    end

    // R10: back-to-back write lands while the platform pulse is high
    @(negedge clk);
    io_addr = 16'h0CF9; io_wdata = 8'h0E; io_wr = 1'b1;
    @(negedge clk);
    check("R10 plat pulse up", {7'd0, plat_rst_pulse}, 8'h01);
    io_addr = 16'h0092; io_wdata = 8'h03;
    @(negedge clk);
    io_wr = 1'b0;
    check("R10 no cpu pulse", {7'd0, cpu_rst_pulse}, 8'h00);
    check("R10 no second plat", {7'd0, plat_rst_pulse}, 8'h00);
    rd(16'h0092, r); check("R10 gate unchanged", r, 8'h00);
    check("R10 a20 low", {7'd0, a20_gate}, 8'h00);

    // R6: a20 set, then async reset mid-run clears everything
    wr_chk("R6 set", 16'h0092, 8'h02, 1'b0, 1'b0);
    check("R6 a20 high", {7'd0, a20_gate}, 8'h01);
    wr_chk("R2 pre", 16'h0CF9, 8'h0A, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 async a20", {7'd0, a20_gate}, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(16'h0CF9, r); check("R1 ctl cleared", r, 8'h00);
    rd(16'h0092, r); check("R1 gate cleared", r, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule